// File: doc/BRIEF.md
# Data-Processing ALU with Flag Generation

This block is the combinational arithmetic and logic stage of a 32-bit integer datapath. It evaluates any one of sixteen data-processing operations on two operands, selected by a 4-bit operation code. It returns the result word, candidate values for the negative, zero, carry and overflow flags, and a set of write enables. The enables tell the surrounding pipeline whether to write the destination register and which flag bits to update.

All subtracting forms use one adder. The adder's operands can be swapped and its second operand inverted, and its carry-in is picked from zero, one or the stored carry flag. The stored carry flag enters as an input so that the add-with-carry and subtract-with-carry forms can use it. The shifter's carry-out also enters as an input, and it supplies the carry flag for logical operations. The flag registers and condition evaluation live outside the block.

Top module: `dp_alu`

## Requirements
- R1: Operation codes are 0 AND, 1 EOR (xor), 12 ORR (or), 13 MOV (pass b), 14 BIC (a and not b) and 15 MVN (not b), and `res_o` carries the matching bitwise result.
- R2: Code 4 ADD gives a+b, code 2 SUB gives a-b and code 3 RSB gives b-a, each modulo 2^W.
- R3: Code 5 ADC gives a+b+cflag_i, code 6 SBC gives a-b-(1-cflag_i) and code 7 RSC gives b-a-(1-cflag_i), each modulo 2^W.
- R4: Codes 8 TST (and), 9 TEQ (xor), 10 CMP (a-b) and 11 CMN (a+b) drive `rd_we_o` low. All other codes drive it high. For these four codes `res_o` still shows the computed value.
- R5: `n_o` equals the top bit of `res_o`, and `z_o` is high exactly when `res_o` is zero.
- R6: For arithmetic codes, `c_o` is the adder carry-out. For the subtracting forms this means 1 when no borrow occurs.
- R7: For arithmetic codes, `v_o` is high exactly when the signed two's-complement result does not fit in W bits.
- R8: For logical codes whose flags are updated, `c_o` equals `shc_i`, `c_we_o` is high and `v_we_o` is low.
- R9: With `setf_i` low and a non-compare code, `nz_we_o`, `c_we_o` and `v_we_o` are all low.
- R10: Arithmetic codes with a flag update (`setf_i` high, or CMP/CMN) raise all three flag enables. Compare codes update flags even when `setf_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand (shifter output) |
| op_i | input | 4 | Operation code |
| setf_i | input | 1 | Flag-update request from the instruction |
| cflag_i | input | 1 | Stored carry flag |
| shc_i | input | 1 | Shifter carry-out |
| res_o | output | W | Operation result |
| n_o | output | 1 | Negative flag value |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| v_o | output | 1 | Overflow flag value |
| rd_we_o | output | 1 | Destination write enable |
| nz_we_o | output | 1 | N and Z update enable |
| c_we_o | output | 1 | C update enable |
| v_we_o | output | 1 | V update enable |

## Verification
Two functions meet in the same evaluation: the result-write decision and the flag-update decision. Compares suppress the first and force the second, while logical operations with a flag update raise the carry enable but not the overflow enable. The bench provokes this by applying compares with `setf_i` low and logical codes with differing `shc_i` values. It then judges each enable and flag against a model that computes carries and overflow from unsigned comparisons and signed range checks, rather than from adder bits.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  typedef enum logic [2:0] {LG_AND, LG_EOR, LG_ORR, LG_PASS, LG_BIC, LG_NOT} logic_fn_e;

  typedef struct packed {
    logic      is_arith;
    logic      swap;
    logic      invert;
    cin_sel_e  cin_sel;
    logic_fn_e lfn;
    logic      no_write;
  } dp_ctrl_t;

  // Signed overflow of x + y = r from sign bits.
  function automatic logic add_ovf(logic sx, logic sy, logic sr);
    return (sx == sy) && (sr != sx);
  endfunction

  function automatic logic pick_cin(cin_sel_e sel, logic flag);
    case (sel)
      CIN_ONE:  return 1'b1;
      CIN_FLAG: return flag;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dp_opdecode.sv
module dp_opdecode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output dp_ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o = '{is_arith: 1'b0, swap: 1'b0, invert: 1'b0,
               cin_sel: CIN_ZERO, lfn: LG_AND, no_write: 1'b0};
    case (dp_op_e'(op_i))
      OP_AND: ctrl_o.lfn = LG_AND;
      OP_EOR: ctrl_o.lfn = LG_EOR;
      OP_SUB: begin ctrl_o.is_arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.cin_sel = CIN_ONE; end
      OP_RSB: begin ctrl_o.is_arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.cin_sel = CIN_ONE; end
      OP_ADD: ctrl_o.is_arith = 1'b1;
      OP_ADC: begin ctrl_o.is_arith = 1'b1; ctrl_o.cin_sel = CIN_FLAG; end
      OP_SBC: begin ctrl_o.is_arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.cin_sel = CIN_FLAG; end
      OP_RSC: begin ctrl_o.is_arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.swap = 1'b1; ctrl_o.cin_sel = CIN_FLAG; end
      OP_TST: begin ctrl_o.lfn = LG_AND; ctrl_o.no_write = 1'b1; end
      OP_TEQ: begin ctrl_o.lfn = LG_EOR; ctrl_o.no_write = 1'b1; end
      OP_CMP: begin ctrl_o.is_arith = 1'b1; ctrl_o.invert = 1'b1; ctrl_o.cin_sel = CIN_ONE; ctrl_o.no_write = 1'b1; end
      OP_CMN: begin ctrl_o.is_arith = 1'b1; ctrl_o.no_write = 1'b1; end
      OP_ORR: ctrl_o.lfn = LG_ORR;
      OP_MOV: ctrl_o.lfn = LG_PASS;
      OP_BIC: ctrl_o.lfn = LG_BIC;
      default: ctrl_o.lfn = LG_NOT;
    endcase
  end
endmodule

// File: rtl/dp_addpath.sv
module dp_addpath
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         swap_i,
  input  logic         invert_i,
  input  cin_sel_e     cin_sel_i,
  input  logic         cflag_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y0, y;
  logic         cin;
  logic [W:0]   wide;

  always_comb begin
    x    = swap_i ? b_i : a_i;
    y0   = swap_i ? a_i : b_i;
    y    = invert_i ? ~y0 : y0;
    cin  = pick_cin(cin_sel_i, cflag_i);
    wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    ovf_o  = add_ovf(x[MSB], y[MSB], wide[MSB]);
  end
endmodule

// File: rtl/dp_logicpath.sv
module dp_logicpath
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_EOR:  y_o = a_i ^ b_i;
      LG_ORR:  y_o = a_i | b_i;
      LG_PASS: y_o = b_i;
      LG_BIC:  y_o = a_i & ~b_i;
      default: y_o = ~b_i;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   op_i,
  input  logic         setf_i,
  input  logic         cflag_i,
  input  logic         shc_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         rd_we_o,
  output logic         nz_we_o,
  output logic         c_we_o,
  output logic         v_we_o
);
  dp_ctrl_t     ctrl;
  logic [W-1:0] sum, lres;
  logic         add_cout, add_ovf_w;
  logic         flag_upd;

  dp_opdecode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  dp_addpath #(.W(W)) u_add (
    .a_i(opa_i), .b_i(opb_i), .swap_i(ctrl.swap), .invert_i(ctrl.invert),
    .cin_sel_i(ctrl.cin_sel), .cflag_i(cflag_i),
    .sum_o(sum), .cout_o(add_cout), .ovf_o(add_ovf_w)
  );

  dp_logicpath #(.W(W)) u_lgc (
    .a_i(opa_i), .b_i(opb_i), .fn_i(ctrl.lfn), .y_o(lres)
  );

  always_comb begin
    res_o    = ctrl.is_arith ? sum : lres;
    n_o      = res_o[W-1];
    z_o      = (res_o == '0);
    c_o      = ctrl.is_arith ? add_cout : shc_i;
    v_o      = ctrl.is_arith ? add_ovf_w : 1'b0;
    flag_upd = setf_i | ctrl.no_write;
    rd_we_o  = ~ctrl.no_write;
    nz_we_o  = flag_upd;
    c_we_o   = flag_upd;
    v_we_o   = flag_upd & ctrl.is_arith;
  end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   op_i,
  input logic         setf_i,
  input logic         cflag_i,
  input logic         shc_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         rd_we_o,
  input logic         nz_we_o,
  input logic         c_we_o,
  input logic         v_we_o
);
  logic is_cmp, is_logic, is_add, unused_ok;

  always_comb begin
    is_cmp    = (op_i[3:2] == 2'b10);
    is_logic  = (op_i == 4'h0) || (op_i == 4'h1) || (op_i == 4'h8) || (op_i == 4'h9) ||
                (op_i[3:2] == 2'b11);
    is_add    = (op_i == 4'h4);
    unused_ok = cflag_i ^ v_o;
    // R4
    result_write_chk: assert (rd_we_o == !is_cmp) else $error("rd_we mismatch");
    // R5
    zero_flag_chk: assert (z_o == (res_o == '0)) else $error("z mismatch");
    // R5
    neg_flag_chk: assert (n_o == res_o[W-1]) else $error("n mismatch");
    // R8
    if (is_logic && nz_we_o) begin
      logic_carry_chk: assert (c_o == shc_i && c_we_o && !v_we_o) else $error("logic carry mismatch");
    end
    // R9
    if (!setf_i && !is_cmp) begin
      quiet_masks_chk: assert (!nz_we_o && !c_we_o && !v_we_o) else $error("masks not quiet");
    end
    // R10
    if (!is_logic && (setf_i || is_cmp)) begin
      arith_masks_chk: assert (nz_we_o && c_we_o && v_we_o) else $error("arith masks low");
    end
    // R2
    if (is_add) begin
      add_sum_chk: assert (res_o == opa_i + opb_i) else $error("add sum mismatch");
    end
  end
endmodule

bind dp_alu dp_alu_chk #(.W(W)) chk_i (
  .opa_i(opa_i), .opb_i(opb_i), .op_i(op_i), .setf_i(setf_i), .cflag_i(cflag_i),
  .shc_i(shc_i), .res_o(res_o), .n_o(n_o), .z_o(z_o), .c_o(c_o), .v_o(v_o),
  .rd_we_o(rd_we_o), .nz_we_o(nz_we_o), .c_we_o(c_we_o), .v_we_o(v_we_o)
);

// File: tb/dp_alu_tb_top.sv
module dp_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa, opb, res;
  logic [3:0]  op;
  logic        setf, cflag, shc;
  logic        n, z, c, v, rd_we, nz_we, c_we, v_we;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dp_alu #(.W(32)) dut_i (
    .opa_i(opa), .opb_i(opb), .op_i(op), .setf_i(setf), .cflag_i(cflag), .shc_i(shc),
    .res_o(res), .n_o(n), .z_o(z), .c_o(c), .v_o(v),
    .rd_we_o(rd_we), .nz_we_o(nz_we), .c_we_o(c_we), .v_we_o(v_we)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s op=%0d a=%h b=%h actual=%h expected=%h", req, what, op, opa, opb, act, exp);
    end
  endtask

  // Independent model: carries from unsigned compares, overflow from signed range.
  task automatic apply(input string req, input logic [3:0] o, input logic [31:0] a, b,
                       input logic s, ci, sc);
    longint ua, ub, sa, sb, u, sv;
    logic [31:0] er;
    logic ec, ev, arith, cmp, upd;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    arith = 1'b1; ec = sc; ev = 1'b0; u = 0; sv = 0; er = '0;
    case (o)
      4'h4, 4'hB: begin u = ua + ub; sv = sa + sb; ec = u[32]; end
      4'h5: begin u = ua + ub + longint'(ci); sv = sa + sb + longint'(ci); ec = u[32]; end
      4'h2, 4'hA: begin u = ua - ub; sv = sa - sb; ec = (ua >= ub); end
      4'h3: begin u = ub - ua; sv = sb - sa; ec = (ub >= ua); end
      4'h6: begin u = ua - ub - longint'(!ci); sv = sa - sb - longint'(!ci); ec = (ua >= ub + longint'(!ci)); end
      4'h7: begin u = ub - ua - longint'(!ci); sv = sb - sa - longint'(!ci); ec = (ub >= ua + longint'(!ci)); end
      default: arith = 1'b0;
    endcase
    if (arith) begin
      er = u[31:0];
      ev = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    end else begin
      case (o)
        4'h0, 4'h8: er = a & b;
        4'h1, 4'h9: er = a ^ b;
        4'hC: er = a | b;
        4'hD: er = b;
        4'hE: er = a & ~b;
        default: er = ~b;
      endcase
    end
    cmp = (o[3:2] == 2'b10);
    upd = s | cmp;
    @(negedge clk);
    op = o; opa = a; opb = b; setf = s; cflag = ci; shc = sc;
    #2;
    chk(req, "result", res, er);
    chk(req, "n", {31'b0, n}, {31'b0, er[31]});
    chk(req, "z", {31'b0, z}, {31'b0, er == 32'b0});
    chk(req, "rd_we", {31'b0, rd_we}, {31'b0, !cmp});
    chk(req, "masks", {29'b0, nz_we, c_we, v_we}, {29'b0, upd, upd, upd & arith});
    if (upd) chk(req, "c", {31'b0, c}, {31'b0, ec});
    if (upd && arith) chk(req, "v", {31'b0, v}, {31'b0, ev});
  endtask

  task automatic t_idle;   // R9 R5: all-zero inputs
    apply("R9", 4'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_logic;  // R1 R8
    apply("R1", 4'h0, 32'hF0F0_1234, 32'hFF00_FF0F, 1'b0, 1'b0, 1'b0);
    apply("R1", 4'h1, 32'hAAAA_5555, 32'h0F0F_F0F0, 1'b0, 1'b1, 1'b1);
    apply("R1", 4'hC, 32'h1200_0034, 32'h0056_7800, 1'b0, 1'b0, 1'b0);
    apply("R1", 4'hD, 32'h1111_1111, 32'h8000_0001, 1'b0, 1'b0, 1'b0);
    apply("R1", 4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0);
    apply("R1", 4'hF, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    apply("R8", 4'hD, 32'h0, 32'h8000_0000, 1'b1, 1'b0, 1'b1);
    apply("R8", 4'h0, 32'h1, 32'h2, 1'b1, 1'b1, 1'b0);
    apply("R8", 4'hF, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_arith;  // R2 R6
    apply("R2", 4'h4, 32'h0000_0005, 32'h0000_0007, 1'b0, 1'b1, 1'b0);
    apply("R2", 4'h2, 32'h0000_0010, 32'h0000_0003, 1'b0, 1'b0, 1'b0);
    apply("R2", 4'h3, 32'h0000_0010, 32'h0000_0003, 1'b0, 1'b0, 1'b0);
    apply("R6", 4'h2, 32'h0000_0003, 32'h0000_0010, 1'b1, 1'b1, 1'b1);
    apply("R6", 4'h2, 32'h0000_0042, 32'h0000_0042, 1'b1, 1'b0, 1'b0);
    apply("R6", 4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    apply("R6", 4'h3, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_carry_ops;  // R3
    for (int ci = 0; ci < 2; ci++) begin
      apply("R3", 4'h5, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 1'(ci), 1'b0);
      apply("R3", 4'h6, 32'h0000_0005, 32'h0000_0005, 1'b1, 1'(ci), 1'b0);
      apply("R3", 4'h7, 32'h0000_0002, 32'h0000_0009, 1'b1, 1'(ci), 1'b0);
      apply("R3", 4'h6, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'(ci), 1'b1);
    end
  endtask

  task automatic t_compare;  // R4 R10
    apply("R4", 4'h8, 32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b0, 1'b1);
    apply("R4", 4'h9, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    apply("R10", 4'hA, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1, 1'b0);
    apply("R10", 4'hB, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;  // R7
    apply("R7", 4'h4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    apply("R7", 4'h2, 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
    apply("R7", 4'h3, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b0, 1'b0);
    apply("R7", 4'h5, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 1'b0);
    apply("R7", 4'h6, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    apply("R7", 4'h4, 32'h4000_0000, 32'hC000_0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_quiet;  // R9: arithmetic without flag request
    apply("R9", 4'h4, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b1);
    apply("R9", 4'h7, 32'h5, 32'h3, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    op = 4'h0; opa = '0; opb = '0; setf = 1'b0; cflag = 1'b0; shc = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_arith();
    t_carry_ops();
    t_compare();
    t_overflow();
    t_quiet();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule